// File: doc/BRIEF.md
# Cascaded Pacer Interval Timer

This block paces analogue conversions. It contains three 16-bit down-counters that are programmed over a byte-wide write bus. One address per counter takes divisor bytes, and a fourth address takes control words. Two of the counters form a chain. Counter 2 divides a periodic reference strobe. Counter 1 divides the output edges of counter 2. The pacer tick therefore repeats every divisor1 × divisor2 reference periods. With a 2 MHz reference (500 ns), a period of 10 µs or more needs a divisor product of at least 20.

Counter 0 is independent of the chain. It runs a one-shot terminal-count function: its output is low while counting and goes high once the programmed number of reference strobes has elapsed.

A control word selects one counter, stops it, and sets how its divisor is loaded and which counting function it performs. Counting restarts only once the divisor is complete.

Top module: `pacer_pit`

## Requirements
- R1: After reset, every counter is idle, `pacer_tick` and `timer0_out` are low, and divisor writes to a counter that has had no control word since reset cause no ticks.
- R2: Control words are written at address 3. Bits 7:6 choose counter 0, 1 or 2, and value 3 is ignored. Bits 5:4 choose the access pattern. Bits 3:1 choose the function: 2 or 6 selects the rate generator, and any other value selects terminal count. A control word is ignored entirely when bits 5:4 are 0 (latch command) or when bit 0 is 1 (decimal counting request).
- R3: A control word stops the chosen counter and resets its byte order, so no ticks come from that counter until the complete new divisor has been written.
- R4: With access pattern 3, the first data write to a counter address supplies the low byte and the second supplies the high byte. The counter starts after the second write.
- R5: Access pattern 1 loads the written byte as the low byte with the high byte zero. Access pattern 2 loads it as the high byte with the low byte zero. In both cases the counter starts at once.
- R6: In rate-generator mode, a counter with divisor N ≥ 2 drives its output low once every N input steps and reloads N at that point.
- R7: Counter 2 steps on `ref_en`, and counter 1 steps on each falling edge of counter 2's output. Once running, `pacer_tick` pulses every divisor1 × divisor2 `ref_en` strobes.
- R8: `pacer_tick` is high for a single clock cycle per pacer period.
- R9: Counter 0 is stepped by `ref_en`. In terminal-count mode, a control word or divisor load drives `timer0_out` low. The output goes high on the N-th following strobe and stays high. A divisor of 0 counts as 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference strobe, one cycle per 500 ns reference period |
| bus_wr | input | 1 | Write strobe of the register bus |
| bus_addr | input | 2 | 0..2 select a counter's divisor, 3 selects the control word |
| bus_wdata | input | 8 | Write data |
| pacer_tick | output | 1 | Single-cycle conversion pacing pulse |
| timer0_out | output | 1 | Output level of counter 0 |

## Verification
The assertions assume that reset is held from time zero and that bus writes are single-cycle strobes with stable address and data. The single-cycle tick property also assumes rate-generator divisors are at least 2, because a divisor of 1 keeps the output low and stops the edges feeding the chain. The stimulus keeps random divisors between 2 and 12 and holds the reference strobe periodic, so each steady tick interval can be predicted exactly. A free-running strobe is used only for the 65536-count case, and the chain is stopped beforehand.

// File: rtl/pacer_pit_pkg.sv
package pacer_pit_pkg;
  localparam int NUM_CNT = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  // Function field decode: 2 and its alias 6 give the rate generator.
  function automatic logic is_rate_mode(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd6);
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pacer_pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [NUM_CNT-1:0] ctl_wr,
  output logic [NUM_CNT-1:0] dat_wr,
  output acc_e              ctl_acc,
  output logic [2:0]        ctl_mode
);
  localparam logic [1:0] CTL_ADDR = 2'd3;

  logic       is_ctl;
  logic       ctl_ok;
  logic [1:0] sel;

  assign is_ctl   = bus_wr && (bus_addr == CTL_ADDR);
  assign sel      = bus_wdata[7:6];
  assign ctl_acc  = acc_e'(bus_wdata[5:4]);
  assign ctl_mode = bus_wdata[3:1];
  assign ctl_ok   = is_ctl && (ctl_acc != ACC_LATCH) && !bus_wdata[0];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign ctl_wr[i] = ctl_ok && (sel == 2'(i));
    assign dat_wr[i] = bus_wr && (bus_addr == 2'(i));
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pacer_pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  acc_e              ctl_acc,
  input  logic [2:0]        ctl_mode,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat,
  input  logic              cnt_en,
  output logic              out_lvl
);
  localparam int CNT_W = 2 * BYTE_W;

  acc_e              acc_q;
  logic              rate_q;
  logic              hi_pend;
  logic              running;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_val;

  // Named internal events.
  logic first_byte;
  logic load_evt;
  logic count_step;
  logic at_one;

  assign first_byte = dat_wr && (acc_q == ACC_LOHI) && !hi_pend;
  assign load_evt   = dat_wr && ((acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                                 ((acc_q == ACC_LOHI) && hi_pend));
  assign count_step = running && cnt_en && !ctl_wr && !first_byte && !load_evt;
  assign at_one     = (cnt_q == CNT_W'(1));

  always_comb begin
    unique case (acc_q)
      ACC_LO:  load_val = {{BYTE_W{1'b0}}, dat};
      ACC_HI:  load_val = {dat, {BYTE_W{1'b0}}};
      default: load_val = {dat, lo_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= ACC_LATCH;
      rate_q   <= 1'b0;
      hi_pend  <= 1'b0;
      running  <= 1'b0;
      lo_q     <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      out_lvl  <= 1'b0;
    end else if (ctl_wr) begin
      acc_q   <= ctl_acc;
      rate_q  <= is_rate_mode(ctl_mode);
      hi_pend <= 1'b0;
      running <= 1'b0;
      out_lvl <= is_rate_mode(ctl_mode);
    end else if (first_byte) begin
      lo_q    <= dat;
      hi_pend <= 1'b1;
      running <= 1'b0;
    end else if (load_evt) begin
      reload_q <= load_val;
      cnt_q    <= load_val;
      hi_pend  <= 1'b0;
      running  <= 1'b1;
      if (!rate_q) out_lvl <= 1'b0;
    end else if (count_step) begin
      if (rate_q) begin
        if (at_one) begin
          cnt_q   <= reload_q;
          out_lvl <= 1'b0;
        end else begin
          cnt_q   <= cnt_q - CNT_W'(1);
          out_lvl <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (at_one) out_lvl <= 1'b1;
      end
    end
  end

  AST_CTL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !running); // R3
  AST_FIRST_BYTE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |=> !running); // R4
  AST_COUNT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(cnt_en || load_evt)); // R6
  AST_TC_FALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_q && $fell(out_lvl)) |-> $past(load_evt || ctl_wr)); // R9
endmodule

// File: rtl/pacer_pit.sv
module pacer_pit
  import pacer_pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic              pacer_tick,
  output logic              timer0_out
);
  logic [NUM_CNT-1:0] ctl_wr;
  logic [NUM_CNT-1:0] dat_wr;
  acc_e               ctl_acc;
  logic [2:0]         ctl_mode;
  logic [NUM_CNT-1:0] cnt_en;
  logic [NUM_CNT-1:0] cnt_out;
  logic               prev_out1;
  logic               prev_out2;
  logic               fall1;
  logic               fall2;

  pit_bus_decode #(.BYTE_W(BYTE_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ctl_wr   (ctl_wr),
    .dat_wr   (dat_wr),
    .ctl_acc  (ctl_acc),
    .ctl_mode (ctl_mode)
  );

  // Counter 2 and counter 0 run from the reference, counter 1 from counter 2.
  assign fall2  = prev_out2 && !cnt_out[2];
  assign fall1  = prev_out1 && !cnt_out[1];
  assign cnt_en = {ref_en, fall2, ref_en};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pit_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (ctl_wr[i]),
      .ctl_acc (ctl_acc),
      .ctl_mode(ctl_mode),
      .dat_wr  (dat_wr[i]),
      .dat     (bus_wdata),
      .cnt_en  (cnt_en[i]),
      .out_lvl (cnt_out[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_out1  <= 1'b0;
      prev_out2  <= 1'b0;
      pacer_tick <= 1'b0;
    end else begin
      prev_out1  <= cnt_out[1];
      prev_out2  <= cnt_out[2];
      pacer_tick <= fall1;
    end
  end

  assign timer0_out = cnt_out[0];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_tick |=> !pacer_tick); // R8
  AST_TICK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_tick |-> $past(prev_out1)); // R7
endmodule

// File: tb/sim_pacer_pit.sv
module sim_pacer_pit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  wire        pacer_tick;
  wire        timer0_out;

  localparam int REF_DIV = 4;

  int  checks = 0;
  int  fails = 0;
  int  cyc = 0;
  int  ref_ph = 0;
  bit  ref_cont = 1'b0;
  bit  done = 1'b0;

  pacer_pit u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pacer_tick(pacer_tick), .timer0_out(timer0_out)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    ref_ph = (ref_ph + 1) % REF_DIV;
    ref_en = ref_cont || (ref_ph == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int exp_period(int d1, int d2);
    return d1 * d2 * REF_DIV;
  endfunction

  function automatic logic [7:0] ctl(int sel, int acc, int mode);
    return 8'((sel << 6) | (acc << 4) | (mode << 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 2'(addr);
    bus_wdata = 8'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic load(int sel, int mode, int val);
    wr(3, ctl(sel, 3, mode));
    wr(sel, val & 255);
    wr(sel, (val >> 8) & 255);
  endtask

  // Waits for one tick, then returns the cycles to the following tick (-1 if none).
  task automatic measure(int lim, output int n);
    bit got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (pacer_tick) begin got = 1'b1; break; end
    end
    n = -1;
    if (got) begin
      for (int i = 1; i <= lim; i++) begin
        @(negedge clk);
        if (pacer_tick) begin n = i; break; end
      end
    end
  endtask

  task automatic count_ticks(int len, output int seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pacer_tick) seen++;
    end
  endtask

  task automatic check_interval(string req, int exp);
    int n;
    measure(2 * exp + 100, n);
    chk(req, n, exp);
  endtask

  task automatic run_pair(string req, int d1, int d2);
    load(2, 2, d2);
    load(1, 2, d1);
    check_interval(req, exp_period(d1, d2));
  endtask

  // Counts reference strobes after a terminal-count load and checks the edge.
  task automatic check_one_shot(int n_exp);
    int k = 0;
    bit hit;
    chk("R9 low after load", int'(timer0_out), 0);
    while (k < n_exp) begin
      @(posedge clk);
      hit = ref_en;
      @(negedge clk);
      if (hit) begin
        k++;
        if (k == n_exp - 1) chk("R9 still low one strobe early", int'(timer0_out), 0);
        if (k == n_exp) chk("R9 high at terminal count", int'(timer0_out), 1);
      end
    end
  endtask

  initial begin
    int n;
    int d1;
    int d2;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tick low after reset", int'(pacer_tick), 0);
    chk("R1 timer0_out low after reset", int'(timer0_out), 0);
    wr(1, 8'h03); wr(1, 8'h00); wr(2, 8'h02); wr(2, 8'h00);
    count_ticks(400, n);
    chk("R1 no ticks without control word", n, 0);

    run_pair("R7 directed 3x2", 3, 2);
    @(negedge clk);
    chk("R8 tick lasts one cycle", int'(pacer_tick), 0);

    run_pair("R4 low then high byte 0x0102", 258, 2);

    for (int t = 0; t < 8; t++) begin
      d1 = 2 + int'($urandom % 11);
      d2 = 2 + int'($urandom % 11);
      run_pair("R6 R7 random divisors", d1, d2);
    end

    load(2, 2, 2);
    wr(3, ctl(1, 1, 2)); wr(1, 7);
    check_interval("R5 low-only access", exp_period(7, 2));
    wr(3, ctl(1, 2, 2)); wr(1, 1);
    check_interval("R5 high-only access", exp_period(256, 2));

    wr(3, ctl(1, 0, 2));
    check_interval("R2 latch command ignored", exp_period(256, 2));
    wr(3, ctl(1, 3, 2) | 8'h01);
    check_interval("R2 decimal request ignored", exp_period(256, 2));
    wr(3, 8'hF4);
    check_interval("R2 select 3 ignored", exp_period(256, 2));
    load(1, 6, 5);
    check_interval("R2 mode 6 is rate generator", exp_period(5, 2));

    wr(3, ctl(1, 3, 2));
    repeat (4) @(negedge clk);
    count_ticks(2000, n);
    chk("R3 control word stops counter", n, 0);
    wr(1, 5);
    count_ticks(2000, n);
    chk("R3 low byte alone does not start", n, 0);
    wr(1, 0);
    check_interval("R3 restart after full divisor", exp_period(5, 2));

    load(0, 0, 10);
    check_one_shot(10);
    repeat (40) @(negedge clk);
    chk("R9 stays high", int'(timer0_out), 1);
    load(0, 0, 6);
    check_one_shot(6);

    wr(3, ctl(2, 3, 2));
    ref_cont = 1'b1;
    load(0, 0, 0);
    check_one_shot(65536);
    ref_cont = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule